// File: doc/BRIEF.md
# Partition Occupancy Status Tracker

This block sits beside one channel's buffer partition and follows the byte traffic going into and out of it. It keeps two 64-bit running totals, one for bytes written and one for bytes read. Their difference is the current occupancy. From the occupancy and a capacity input, the block drives a write-accept signal to the producer and a live full flag. It also keeps a sticky overflow flag, which records that a write request was refused. The block does not hold the buffer memory and does not parse packets.

The producer marks the write that carries the last byte of the last packet. The block then remembers the total byte count at that point. It reports the stream as flushed only once the read total has reached that count. If the stream has ended but the read total is still behind the write total, data is stuck in the partition, and the flushed flag stays low. A host polls the outputs. A single clear input, or the reset, returns all totals and flags to zero.

Top module: `part_occ_tracker`

## Requirements
- R1: An accepted write of N bytes adds N to `bytes_wr_o`, and a read adds its applied amount to `bytes_rd_o`. Both totals update one clock edge after the strobe.
- R2: The amount a read applies is the smaller of `rd_len_i` and the occupancy (`bytes_wr_o - bytes_rd_o`) at the start of that cycle. A read larger than the occupancy only drains the partition to empty.
- R3: `full_o` is high exactly when the occupancy (`bytes_wr_o - bytes_rd_o`) is greater than or equal to `cap_i`. It falls once reads free space.
- R4: `wr_accept_o` is high exactly when the occupancy plus `wr_len_i` does not exceed `cap_i`. A write request made while it is low is dropped: `bytes_wr_o` does not change, and `ovf_o` is high from the next edge.
- R5: When a read and a write fall in the same cycle, both are applied to the totals in that cycle. Write acceptance is judged on the occupancy before the read. `full_o` reflects both updates after the edge.
- R6: `ovf_o`, once set, stays high until `clr_i` or reset.
- R7: An accepted write with `eos_i` high records the new write total as the end mark. `flushed_o` is high once `bytes_rd_o` has reached that mark. It stays low while reads are still behind the mark.
- R8: A dropped write that carries `eos_i` records no end mark. `flushed_o` stays low after it.
- R9: `clr_i` zeroes both totals and clears `ovf_o` and the end-of-stream state on the next edge. It overrides any read or write in the same cycle.
- R10: After reset, both totals are zero and `full_o`, `ovf_o` and `flushed_o` are low, given a nonzero `cap_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous clear of totals and flags |
| cap_i | input | CAP_W | Partition capacity in bytes |
| wr_req_i | input | 1 | Write request strobe |
| wr_len_i | input | LEN_W | Byte count of the write |
| eos_i | input | 1 | This write carries the last byte of the stream |
| rd_i | input | 1 | Read strobe |
| rd_len_i | input | LEN_W | Byte count of the read |
| wr_accept_o | output | 1 | The write of `wr_len_i` bytes fits |
| bytes_wr_o | output | 64 | Total bytes written |
| bytes_rd_o | output | 64 | Total bytes read |
| full_o | output | 1 | Live full status |
| ovf_o | output | 1 | Sticky overflow |
| flushed_o | output | 1 | Last byte of the stream has been read |

## Verification
A read and a write can both update the totals in the same cycle. The read is clipped against the old occupancy, while acceptance of the write ignores the space that read frees. The bench provokes this in two ways. It writes exactly enough to reach capacity while reading a few bytes. It also writes one byte too many while reading, which must still be refused. A reference model applies the rules in the stated order, and the bench compares the totals, the full flag and the overflow flag after each edge. A clear issued together with traffic is checked the same way, and the expected result is all zeros.

// File: rtl/part_occ_pkg.sv
package part_occ_pkg;
  localparam int unsigned CNT_W = 64;
  typedef logic [CNT_W-1:0] cnt_t;
endpackage

// File: rtl/occ_byte_ctr.sv
module occ_byte_ctr
  import part_occ_pkg::*;
#(
  parameter int unsigned LEN_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  input  logic [LEN_W-1:0] amt_i,
  output cnt_t             cnt_o
);
  cnt_t cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + cnt_t'(amt_i);
  end

  assign cnt_o = cnt_q;

  // monotonic between clears (R1)
  p_ctr_mono_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> cnt_q >= $past(cnt_q));
endmodule

// File: rtl/occ_eos_flags.sv
module occ_eos_flags
  import part_occ_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic drop_i,
  input  logic eos_wr_i,
  input  cnt_t mark_i,
  input  cnt_t bytes_rd_i,
  output logic ovf_o,
  output logic flushed_o
);
  logic ovf_q, eos_q;
  cnt_t mark_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovf_q  <= 1'b0;
      eos_q  <= 1'b0;
      mark_q <= '0;
    end else if (clr_i) begin
      ovf_q  <= 1'b0;
      eos_q  <= 1'b0;
      mark_q <= '0;
    end else begin
      if (drop_i) ovf_q <= 1'b1;
      if (eos_wr_i) begin
        eos_q  <= 1'b1;
        mark_q <= mark_i;
      end
    end
  end

  assign ovf_o     = ovf_q;
  assign flushed_o = eos_q && (bytes_rd_i >= mark_q);

  p_ovf_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o && !clr_i |=> ovf_o);
  p_drop_sets_ovf_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_i && !clr_i |=> ovf_o);
  p_flush_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flushed_o && !clr_i && !eos_wr_i |=> flushed_o);
endmodule

// File: rtl/part_occ_tracker.sv
module part_occ_tracker
  import part_occ_pkg::*;
#(
  parameter int unsigned LEN_W = 16,
  parameter int unsigned CAP_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [CAP_W-1:0] cap_i,
  input  logic             wr_req_i,
  input  logic [LEN_W-1:0] wr_len_i,
  input  logic             eos_i,
  input  logic             rd_i,
  input  logic [LEN_W-1:0] rd_len_i,
  output logic             wr_accept_o,
  output logic [63:0]      bytes_wr_o,
  output logic [63:0]      bytes_rd_o,
  output logic             full_o,
  output logic             ovf_o,
  output logic             flushed_o
);
  localparam int unsigned SUM_W = CNT_W + 1;

  cnt_t             wr_tot, rd_tot, occ, cap_ext;
  logic [SUM_W-1:0] need;
  logic [LEN_W-1:0] rd_amt;
  logic             wr_do, drop;

  assign occ     = wr_tot - rd_tot;
  assign cap_ext = cnt_t'(cap_i);
  assign need    = {1'b0, occ} + SUM_W'(wr_len_i);

  assign wr_accept_o = need <= {1'b0, cap_ext};
  assign wr_do       = wr_req_i && wr_accept_o;
  assign drop        = wr_req_i && !wr_accept_o;

  // clip read to current occupancy
  always_comb begin
    if (cnt_t'(rd_len_i) <= occ) rd_amt = rd_len_i;
    else                         rd_amt = occ[LEN_W-1:0];
  end

  occ_byte_ctr #(.LEN_W(LEN_W)) u_wr_ctr (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr_i),
    .inc_i(wr_do), .amt_i(wr_len_i), .cnt_o(wr_tot)
  );

  occ_byte_ctr #(.LEN_W(LEN_W)) u_rd_ctr (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr_i),
    .inc_i(rd_i), .amt_i(rd_amt), .cnt_o(rd_tot)
  );

  occ_eos_flags u_flags (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr_i),
    .drop_i(drop), .eos_wr_i(wr_do && eos_i),
    .mark_i(wr_tot + cnt_t'(wr_len_i)), .bytes_rd_i(rd_tot),
    .ovf_o(ovf_o), .flushed_o(flushed_o)
  );

  assign full_o     = occ >= cap_ext;
  assign bytes_wr_o = wr_tot;
  assign bytes_rd_o = rd_tot;

  p_no_underflow_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bytes_rd_o <= bytes_wr_o);
  p_drop_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_i && !wr_accept_o && !clr_i |=> $stable(bytes_wr_o));
  p_full_blocks_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o && wr_len_i != '0 |-> !wr_accept_o);
  p_clr_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> bytes_wr_o == '0 && bytes_rd_o == '0 && !ovf_o && !flushed_o);
endmodule

// File: tb/part_occ_tracker_tb.sv
module part_occ_tracker_tb;
  localparam int unsigned LEN_W = 16;
  localparam int unsigned CAP_W = 32;

  typedef struct {
    longint unsigned wr, rd;
    bit full, ovf, fl;
    string tag;
  } exp_t;

  logic clk = 1'b0, rst_ni = 1'b0, clr = 1'b0;
  logic [CAP_W-1:0] cap = 32'd100;
  logic wr_req = 1'b0, eos = 1'b0, rd = 1'b0;
  logic [LEN_W-1:0] wr_len = '0, rd_len = '0;
  logic wr_acc, full, ovf, fl;
  logic [63:0] bwr, brd;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;
  exp_t q[$];

  longint unsigned m_wr = 0, m_rd = 0, m_mark = 0;
  bit m_ovf = 0, m_eos = 0;

  always #5 clk = ~clk;

  part_occ_tracker #(.LEN_W(LEN_W), .CAP_W(CAP_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .clr_i(clr), .cap_i(cap),
    .wr_req_i(wr_req), .wr_len_i(wr_len), .eos_i(eos),
    .rd_i(rd), .rd_len_i(rd_len), .wr_accept_o(wr_acc),
    .bytes_wr_o(bwr), .bytes_rd_o(brd), .full_o(full),
    .ovf_o(ovf), .flushed_o(fl)
  );

  task automatic step(input bit w, input int wl, input bit e, input bit r,
                      input int rl, input bit c, input string tag);
    longint unsigned occ, ra;
    bit acc;
    exp_t x;
    @(negedge clk);
    wr_req = w; wr_len = LEN_W'(wl); eos = e; rd = r; rd_len = LEN_W'(rl); clr = c;
    occ = m_wr - m_rd;
    acc = (occ + longint'(wl)) <= longint'(cap);
    #1;
    n_cmp++;
    if (wr_acc !== acc) begin
      n_bad++;
      $display("FAIL %s R4 accept: got %0b exp %0b", tag, wr_acc, acc);
    end
    if (c) begin
      m_wr = 0; m_rd = 0; m_ovf = 0; m_eos = 0; m_mark = 0;
    end else begin
      ra = (longint'(rl) <= occ) ? longint'(rl) : occ;
      if (w && acc) begin
        m_wr += longint'(wl);
        if (e) begin m_eos = 1; m_mark = m_wr; end
      end
      if (w && !acc) m_ovf = 1;
      if (r) m_rd += ra;
    end
    x.wr = m_wr; x.rd = m_rd; x.full = (m_wr - m_rd) >= longint'(cap);
    x.ovf = m_ovf; x.fl = m_eos && (m_rd >= m_mark); x.tag = tag;
    q.push_back(x);
  endtask

  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      exp_t x;
      x = q.pop_front();
      n_cmp++;
      if (bwr !== x.wr || brd !== x.rd || full !== x.full || ovf !== x.ovf || fl !== x.fl) begin
        n_bad++;
        $display("FAIL %s: got wr=%0d rd=%0d full=%0b ovf=%0b fl=%0b exp wr=%0d rd=%0d full=%0b ovf=%0b fl=%0b",
                 x.tag, bwr, brd, full, ovf, fl, x.wr, x.rd, x.full, x.ovf, x.fl);
      end
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    n_cmp++;
    if (bwr !== 0 || brd !== 0 || full !== 0 || ovf !== 0 || fl !== 0) begin
      n_bad++;
      $display("FAIL R10 reset: got wr=%0d rd=%0d full=%0b ovf=%0b fl=%0b exp all 0", bwr, brd, full, ovf, fl);
    end
    rst_ni = 1'b1;
    step(1, 40, 0, 0, 0, 0, "R1 write 40");
    step(1, 60, 0, 0, 0, 0, "R3 fill to cap");
    step(1, 0, 0, 0, 0, 0, "R4 zero write at full");
    step(1, 1, 0, 0, 0, 0, "R4 drop at full");
    step(0, 0, 0, 0, 0, 0, "R6 ovf holds");
    step(0, 0, 0, 1, 30, 0, "R3 read frees space");
    step(1, 30, 0, 1, 10, 0, "R5 fill with same-cycle read");
    step(1, 11, 0, 1, 5, 0, "R5 over by one with read");
    step(0, 0, 0, 1, 500, 0, "R2 read clipped");
    step(0, 0, 0, 1, 4, 0, "R2 read when empty");
    step(1, 7, 0, 1, 3, 1, "R9 clear with traffic");
    step(1, 20, 1, 0, 0, 0, "R7 eos write");
    step(0, 0, 0, 1, 10, 0, "R7 partly read");
    step(1, 5, 0, 0, 0, 0, "R7 stuck still");
    step(0, 0, 0, 1, 10, 0, "R7 mark reached");
    step(0, 0, 0, 1, 5, 0, "R7 flushed holds");
    step(0, 0, 0, 0, 0, 1, "R9 clear");
    step(1, 90, 0, 0, 0, 0, "R1 write 90");
    step(1, 20, 1, 0, 0, 0, "R8 dropped eos");
    step(0, 0, 0, 1, 90, 0, "R8 drained no flush");
    step(0, 0, 0, 0, 0, 0, "R6 ovf still set");
    step(0, 0, 0, 0, 0, 0, "idle");
    @(negedge clk);
    wr_req = 0; rd = 0; clr = 0; eos = 0;
    repeat (3) @(posedge clk);
    #3;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule